// File: doc/BRIEF.md
# Serial Memory Write-Protect Controller

This block holds the status register and the write-protection decisions of a serial nonvolatile byte memory with 2^17 locations. A command decoder in front of it hands over single-cycle strobes for write-enable, write-disable, status-register update and memory write. It also passes a command data byte, a target address for memory writes, and the level of an active-low hardware protect pin.

For each memory write strobe, the block answers in the same cycle with a grant. The grant is high only if the write-enable latch is set and the address lies outside the protected region. For each status-update strobe, it answers in the same cycle with a grant. That grant is high only if the latch is set and the pin lock is not engaged. A pin lock means the lock-enable bit is set and the pin is low. The status byte it presents is what a status read returns.

At most one strobe is asserted in any cycle. The values that stand in for nonvolatile storage come from parameters at reset.

Top module: `wpc_top`

## Requirements
- R1: Status bit 6 always reads 1, and bits 5, 4 and 0 always read 0. This holds from reset and after any status update, whatever byte was written.
- R2: A granted status update copies data bit 7 into status bit 7 (lock enable) and data bits 3:2 into status bits 3:2 (region select), visible after the next clock edge.
- R3: A write-enable strobe sets status bit 1 (the latch) after the next edge, and a write-disable strobe clears it. A status update never sets the latch, even when data bit 1 is 1.
- R4: A granted status update clears the latch after the next edge.
- R5: The status-update grant is high in the strobe's cycle exactly when the latch is 1 and not (bit 7 = 1 and the pin is low).
- R6: While status bit 7 is 0, the pin level changes neither grant.
- R7: A refused status update leaves all eight status bits unchanged, including the latch.
- R8: The memory-write grant is high in the strobe's cycle exactly when the latch is 1 and the address is outside the protected region.
- R9: The region select decodes as follows: 00 protects nothing, 01 protects 18000h–1FFFFh, 10 protects 10000h–1FFFFh, and 11 protects every address.
- R10: A memory write, whether granted or not, leaves the status byte unchanged.
- R11: Reset clears the latch and loads bit 7 and bits 3:2 from the parameters PWR_LOCK and PWR_REGION.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-update strobe |
| cmd_mwr | input | 1 | Memory-write strobe |
| cmd_byte | input | 8 | Command data byte (new status value for updates) |
| mwr_addr | input | 17 | Memory-write target address |
| wp_n | input | 1 | Hardware protect pin, active low |
| status_q | output | 8 | Status byte for reads |
| mwr_grant | output | 1 | Memory write allowed this cycle |
| wrsr_grant | output | 1 | Status update allowed this cycle |

## Verification
The bench sweeps all four region codes and both lock settings. It probes addresses one below and at each region boundary, as well as the top and bottom of memory. A design off by one at 10000h or 18000h would grant or refuse the wrong boundary byte.

The bench writes bytes that have every fixed bit and the latch bit inverted. A design that stored the raw byte would show stray bits or a latch set by an update.

It crosses pin level, lock bit and latch state on status updates. A lock that ignored bit 7, or a refusal that still cleared the latch, shows up as a wrong grant or a changed status byte. It also repeats memory writes with the latch set and confirms the latch survives them.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int STATUS_W = 8;

    typedef enum logic [1:0] {
        REGION_NONE    = 2'b00,
        REGION_QUARTER = 2'b01,
        REGION_HALF    = 2'b10,
        REGION_ALL     = 2'b11
    } region_e;

    typedef struct packed {
        logic       lock_en;
        logic       fixed_one;
        logic [1:0] fixed_zero;
        region_e    region;
        logic       wel;
        logic       busy;
    } status_t;

    function automatic status_t make_status(input logic lock_en,
                                            input region_e region,
                                            input logic wel);
        status_t s;
        s.lock_en    = lock_en;
        s.fixed_one  = 1'b1;
        s.fixed_zero = 2'b00;
        s.region     = region;
        s.wel        = wel;
        s.busy       = 1'b0;
        return s;
    endfunction

    function automatic status_t status_from_byte(input logic [STATUS_W-1:0] b);
        return make_status(b[7], region_e'(b[3:2]), 1'b0);
    endfunction

endpackage

// File: rtl/wpc_region_guard.sv
module wpc_region_guard
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  region_e           region,
    input  logic [ADDR_W-1:0] addr,
    output logic              blocked
);
    localparam logic [ADDR_W:0] SPAN      = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] HALF_LO   = SPAN >> 1;
    localparam logic [ADDR_W:0] QUART_LO  = HALF_LO + (SPAN >> 2);

    logic [ADDR_W:0] lower;
    logic [ADDR_W:0] addr_x;

    always_comb begin
        unique case (region)
            REGION_NONE:    lower = SPAN;
            REGION_QUARTER: lower = QUART_LO;
            REGION_HALF:    lower = HALF_LO;
            default:        lower = '0;
        endcase
    end

    assign addr_x  = {1'b0, addr};
    assign blocked = (addr_x >= lower);

endmodule

// File: rtl/wpc_status_reg.sv
module wpc_status_reg
    import wpc_pkg::*;
#(
    parameter logic    PWR_LOCK   = 1'b0,
    parameter region_e PWR_REGION = REGION_NONE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_wel,
    input  logic                clr_wel,
    input  logic                load,
    input  logic [STATUS_W-1:0] load_byte,
    output status_t             status
);
    status_t status_d;

    always_comb begin
        status_d = status;
        if (load) begin
            status_d = status_from_byte(load_byte);
        end else if (clr_wel) begin
            status_d.wel = 1'b0;
        end else if (set_wel) begin
            status_d.wel = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= make_status(PWR_LOCK, PWR_REGION, 1'b0);
        end else begin
            status <= status_d;
        end
    end

endmodule

// File: rtl/wpc_top.sv
module wpc_top
    import wpc_pkg::*;
#(
    parameter int      ADDR_W     = 17,
    parameter logic    PWR_LOCK   = 1'b0,
    parameter region_e PWR_REGION = REGION_NONE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_mwr,
    input  logic [7:0]        cmd_byte,
    input  logic [ADDR_W-1:0] mwr_addr,
    input  logic              wp_n,
    output logic [7:0]        status_q,
    output logic              mwr_grant,
    output logic              wrsr_grant
);
    status_t status;
    logic    addr_blocked;
    logic    pin_lock;

    wpc_status_reg #(
        .PWR_LOCK   (PWR_LOCK),
        .PWR_REGION (PWR_REGION)
    ) u_sreg (
        .clk       (clk),
        .rst       (rst),
        .set_wel   (cmd_wren),
        .clr_wel   (cmd_wrdi),
        .load      (wrsr_grant),
        .load_byte (cmd_byte),
        .status    (status)
    );

    wpc_region_guard #(
        .ADDR_W (ADDR_W)
    ) u_guard (
        .region  (status.region),
        .addr    (mwr_addr),
        .blocked (addr_blocked)
    );

    assign pin_lock   = status.lock_en & ~wp_n;
    assign wrsr_grant = cmd_wrsr & status.wel & ~pin_lock;
    assign mwr_grant  = cmd_mwr & status.wel & ~addr_blocked;
    assign status_q   = status;

endmodule

// File: rtl/wpc_top_chk.sv
module wpc_top_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_wrsr,
    input logic       cmd_mwr,
    input logic       wp_n,
    input logic [7:0] status_q,
    input logic       mwr_grant,
    input logic       wrsr_grant
);
    logic only_wrsr, only_mwr, only_wren;
    assign only_wrsr = cmd_wrsr & ~cmd_wren & ~cmd_wrdi & ~cmd_mwr;
    assign only_mwr  = cmd_mwr & ~cmd_wren & ~cmd_wrdi & ~cmd_wrsr;
    assign only_wren = cmd_wren & ~cmd_wrdi & ~cmd_wrsr;

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        status_q[6] && !status_q[5] && !status_q[4] && !status_q[0]); // R1
    AST_WREN_SETS: assert property (@(posedge clk) disable iff (rst)
        only_wren |=> status_q[1]); // R3
    AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd_wrdi |=> !status_q[1]); // R3
    AST_SR_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
        wrsr_grant |=> !status_q[1]); // R4
    AST_SR_GATED: assert property (@(posedge clk) disable iff (rst)
        wrsr_grant |-> status_q[1] && !(status_q[7] && !wp_n)); // R5
    AST_SR_REFUSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        only_wrsr && !wrsr_grant |=> $stable(status_q)); // R7
    AST_MWR_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        mwr_grant |-> status_q[1]); // R8
    AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (rst)
        status_q[3:2] == 2'b11 |-> !mwr_grant); // R9
    AST_MWR_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
        only_mwr |=> $stable(status_q)); // R10

endmodule

bind wpc_top wpc_top_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_wren   (cmd_wren),
    .cmd_wrdi   (cmd_wrdi),
    .cmd_wrsr   (cmd_wrsr),
    .cmd_mwr    (cmd_mwr),
    .wp_n       (wp_n),
    .status_q   (status_q),
    .mwr_grant  (mwr_grant),
    .wrsr_grant (wrsr_grant)
);

// File: tb/wpc_top_test.sv
`timescale 1ns/1ps
module wpc_top_test;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_wren, cmd_wrdi, cmd_wrsr, cmd_mwr;
    logic [7:0]    cmd_byte;
    logic [AW-1:0] mwr_addr;
    logic          wp_n;
    logic [7:0]    status_q;
    logic          mwr_grant, wrsr_grant;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic       m_lock;
    logic [1:0] m_reg;
    logic       m_wel;

    always #2.5 clk = ~clk;

    wpc_top #(.ADDR_W(AW), .PWR_LOCK(1'b1), .PWR_REGION(wpc_pkg::REGION_QUARTER)) uut (
        .clk(clk), .rst(rst), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .cmd_mwr(cmd_mwr), .cmd_byte(cmd_byte),
        .mwr_addr(mwr_addr), .wp_n(wp_n), .status_q(status_q),
        .mwr_grant(mwr_grant), .wrsr_grant(wrsr_grant)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_lock, 1'b1, 2'b00, m_reg, m_wel, 1'b0};
    endfunction

    function automatic logic in_region(input logic [1:0] r, input int a);
        int lo;
        case (r)
            2'd0: lo = 1 << AW;
            2'd1: lo = 3 << (AW - 2);
            2'd2: lo = 1 << (AW - 1);
            default: lo = 0;
        endcase
        return a >= lo;
    endfunction

    task automatic idle();
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_mwr = 0;
    endtask

    // kind: 0 wren, 1 wrdi, 2 wrsr, 3 mwr
    task automatic do_cmd(input int kind, input logic [7:0] b, input int a,
                          input logic pin, input string req);
        logic g;
        @(negedge clk);
        idle();
        cmd_byte = b; mwr_addr = a[AW-1:0]; wp_n = pin;
        case (kind)
            0: cmd_wren = 1;
            1: cmd_wrdi = 1;
            2: cmd_wrsr = 1;
            default: cmd_mwr = 1;
        endcase
        #1;
        if (kind == 2) begin
            g = m_wel && !(m_lock && !pin);
            chk({req, " wrsr_grant"}, int'(wrsr_grant), int'(g));
            if (g) begin m_lock = b[7]; m_reg = b[3:2]; m_wel = 0; end
        end else if (kind == 3) begin
            g = m_wel && !in_region(m_reg, a);
            chk({req, " mwr_grant"}, int'(mwr_grant), int'(g));
        end else if (kind == 0) begin
            m_wel = 1;
        end else begin
            m_wel = 0;
        end
        @(negedge clk);
        idle();
        #1;
        chk({req, " status"}, int'(status_q), int'(exp_status()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(); cmd_byte = 0; mwr_addr = 0; wp_n = 1; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R11: reset state from parameters (lock=1, region=01), latch clear
        m_lock = 1; m_reg = 2'b01; m_wel = 0;
        chk("R11 reset status", int'(status_q), int'(exp_status()));
        chk("R1 reset fixed bits", int'(status_q & 8'h71), 32'h40);

        // R5/R7: latch clear, update refused, status unchanged
        do_cmd(2, 8'h00, 0, 1'b1, "R7 no-wel");
        // R8: latch clear, memory write refused at address 0
        do_cmd(3, 8'h00, 0, 1'b1, "R8 no-wel");
        // R5/R7: pin lock engaged with latch set
        do_cmd(0, 8'h00, 0, 1'b1, "R3 wren");
        do_cmd(2, 8'h00, 0, 1'b0, "R7 pin-locked");
        chk("R7 wel kept", int'(status_q[1]), 1);
        // R5: pin high lets update through; R1/R2/R3/R4 with inverted junk bits
        do_cmd(2, 8'h3B, 0, 1'b1, "R2 load");
        chk("R3 no-set-by-write", int'(status_q[1]), 0);
        chk("R1 fixed after write", int'(status_q & 8'h71), 32'h40);

        // R6: lock off, pin low has no effect on either grant
        for (int p = 0; p < 2; p++) begin
            do_cmd(0, 8'h00, 0, 1'b1, "R3 wren");
            do_cmd(3, 8'h00, 32'h100, p[0], "R6 mwr");
            do_cmd(2, 8'h00, 0, p[0], "R6 wrsr");
        end

        // cross lock/pin/latch on status updates
        for (int lk = 0; lk < 2; lk++)
            for (int p = 0; p < 2; p++)
                for (int w = 0; w < 2; w++) begin
                    do_cmd(0, 8'h00, 0, 1'b1, "R3 wren");
                    do_cmd(2, {lk[0], 7'h00}, 0, 1'b1, "R2 set lock");
                    if (w == 1) do_cmd(0, 8'h00, 0, 1'b1, "R3 wren");
                    else        do_cmd(1, 8'h00, 0, 1'b1, "R3 wrdi");
                    do_cmd(2, 8'h8C, 0, p[0], "R5 cross");
                end

        // region sweep: every region code, both latch states
        for (int r = 0; r < 4; r++) begin
            do_cmd(0, 8'h00, 0, 1'b1, "R3 wren");
            do_cmd(2, {4'h0, r[1:0], 2'b11}, 0, 1'b1, "R2 region");
            for (int w = 0; w < 2; w++) begin
                if (w == 1) do_cmd(0, 8'h00, 0, 1'b1, "R3 wren");
                for (int a = 0; a < (1 << AW); a += 32'h800)
                    do_cmd(3, 8'hA5, a, 1'b1, "R9 sweep");
                do_cmd(3, 8'h00, 32'hFFFF,  1'b1, "R9 below half");
                do_cmd(3, 8'h00, 32'h10000, 1'b1, "R9 at half");
                do_cmd(3, 8'h00, 32'h17FFF, 1'b1, "R9 below quarter");
                do_cmd(3, 8'h00, 32'h18000, 1'b1, "R9 at quarter");
                do_cmd(3, 8'h00, 32'h1FFFF, 1'b1, "R9 top");
                do_cmd(3, 8'h00, 32'h0,     1'b1, "R9 bottom");
                // R10: latch survives a run of memory writes
                if (w == 1) chk("R10 wel kept", int'(status_q[1]), 1);
            end
        end

        do_cmd(1, 8'h00, 0, 1'b1, "R3 wrdi");
        chk("R3 cleared", int'(status_q[1]), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule